// File: doc/BRIEF.md
# Register-Write Sequence Bank Switcher

This block sits beside a CPU's peripheral register window and watches every write that lands there. Only one exact chain of register writes, some of them carrying fixed data values, arms a bank change. The bank change swaps which 32 KB half of a 64 KB cartridge memory answers CPU reads in the lower half of the address space. The new half is chosen by the first write in the chain. It takes effect only when a later write to a separate register arrives while the chain is complete.

The block turns the CPU read address into a 16-bit cartridge memory address by adding the active bank offset, with wrap-around. The current position in the chain is exported for debug. The peripheral registers keep their own normal function elsewhere. This block only observes the writes and never blocks them.

Top module: `bank_seq_switch`

## Requirements
- R1: After a synchronous active-low reset, `seq_state` is 0, and both the active offset and the pending offset are 0, so `cart_addr` equals `rd_addr`.
- R2: A window write to register 2 moves `seq_state` to 1 from any state. It also latches the pending offset: 0 when data bit 6 is 1, otherwise 0x8000.
- R3: A window write to register 3 moves state 1 to state 2. In any other state it moves the sequencer to state 0.
- R4: A window write to register 0 moves state 2 to state 3 only when the data is 0x01. In every other case it moves the sequencer to state 0.
- R5: A window write to register 1 moves state 3 to state 4 only when the data is 0x00. In every other case it moves the sequencer to state 0.
- R6: A window write to register 11 moves state 4 to state 5 only when the data is 0x98. In every other case it moves the sequencer to state 0.
- R7: A window write to register 4 in state 5 copies the pending offset into the active offset and moves the sequencer to state 0. In states 0 to 4, a register 4 write changes neither the state nor the active offset.
- R8: `cart_addr` equals (`rd_addr` + active offset) mod 65536. It follows `rd_addr` in the same cycle, with no register in the path.
- R9: A write is a window write only when `wr_en` is 1 and `wr_addr` bit 12 is 1. The register number is `wr_addr[3:0]`, and all other address bits are ignored. Writes outside the window, writes to registers 5 to 10 and 12 to 15, and cycles with `wr_en` low change neither the state nor the offsets.
- R10: `seq_state` reports the chain position as a 3-bit number from 0 (idle) to 5 (ready to commit). Any state change is visible one clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_addr | input | 16 | CPU write address |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | CPU write data |
| rd_addr | input | 16 | CPU read address into the cartridge range |
| cart_addr | output | 16 | Cartridge memory address after the bank offset is added |
| seq_state | output | 3 | Current sequencer state, for debug |

## Verification
The sequencer state and both offsets change on the clock edge that samples `wr_en` high, so they are due one edge after the write. The bench drives each write for one full cycle between falling edges and reads `seq_state` at the next falling edge. The translated address has no register in its path, so the bench reads it 1 ns after each change of `rd_addr`, in a cycle with no write pending. It sweeps read addresses across the lower half after every commit and after every rejected chain. It also sweeps all sixteen register numbers and a range of data values at each step of the chain.

// File: rtl/bsw_pkg.sv
// Package: shared state encoding and decoded write operations for the
// sequence bank switcher. Assumes a 3-bit state register.
package bsw_pkg;
    localparam int STATE_W = 3;

    localparam logic [STATE_W-1:0] ST_IDLE  = 3'd0;
    localparam logic [STATE_W-1:0] ST_ARMED = 3'd1;
    localparam logic [STATE_W-1:0] ST_CONF  = 3'd2;
    localparam logic [STATE_W-1:0] ST_KEY1  = 3'd3;
    localparam logic [STATE_W-1:0] ST_KEY2  = 3'd4;
    localparam logic [STATE_W-1:0] ST_READY = 3'd5;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_ARM    = 3'd1,
        OP_CONF   = 3'd2,
        OP_KEYA   = 3'd3,
        OP_KEYB   = 3'd4,
        OP_KEYC   = 3'd5,
        OP_COMMIT = 3'd6
    } wr_op_t;
endpackage

// File: rtl/bsw_decode.sv
// Module: bsw_decode
// Turns a CPU write into one of the chain operations. A write counts only
// when the strobe is high and the window address bit is set. The register
// number is taken from the low SEL_W address bits.
// Assumes: WIN_BIT >= SEL_W, so the window bit is not a select bit.
module bsw_decode
    import bsw_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WIN_BIT    = 12,
    parameter int SEL_W      = 4,
    parameter int REG_ARM    = 2,
    parameter int REG_CONF   = 3,
    parameter int REG_KEYA   = 0,
    parameter int REG_KEYB   = 1,
    parameter int REG_KEYC   = 11,
    parameter int REG_COMMIT = 4
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    output wr_op_t            op
);
    localparam logic [ADDR_W-1:0] SEL_MASK  = ADDR_W'((1 << SEL_W) - 1);
    localparam logic [ADDR_W-1:0] WIN_MASK  = ADDR_W'(1) << WIN_BIT;
    localparam logic [ADDR_W-1:0] USED_MASK = SEL_MASK | WIN_MASK;

    logic [SEL_W-1:0] sel;
    logic             hit;
    logic             unused_addr_bits;

    assign sel = wr_addr[SEL_W-1:0];
    assign hit = wr_en & wr_addr[WIN_BIT];
    assign unused_addr_bits = ^(wr_addr & ~USED_MASK);

    // Map a window write to its chain operation.
    always_comb begin
        op = OP_NONE;
        if (hit) begin
            if      (sel == SEL_W'(REG_ARM))    op = OP_ARM;
            else if (sel == SEL_W'(REG_CONF))   op = OP_CONF;
            else if (sel == SEL_W'(REG_KEYA))   op = OP_KEYA;
            else if (sel == SEL_W'(REG_KEYB))   op = OP_KEYB;
            else if (sel == SEL_W'(REG_KEYC))   op = OP_KEYC;
            else if (sel == SEL_W'(REG_COMMIT)) op = OP_COMMIT;
        end
    end
endmodule

// File: rtl/bsw_seq.sv
// Module: bsw_seq
// Six-state chain tracker. It advances only on the exact register and data
// order, and drops to idle on any step that is out of order. It flags a
// commit when the commit register is written in the ready state.
// Assumes: op is already qualified by the write strobe. Encodings 6 and 7
// behave as idle.
module bsw_seq
    import bsw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] KEYA_VAL = 8'h01,
    parameter logic [DATA_W-1:0] KEYB_VAL = 8'h00,
    parameter logic [DATA_W-1:0] KEYC_VAL = 8'h98
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wr_op_t             op,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [STATE_W-1:0] state,
    output logic               commit
);
    logic [STATE_W-1:0] state_nx;

    // A commit needs the commit write while the chain is ready.
    assign commit = (op == OP_COMMIT) && (state == ST_READY);

    // Next state from the current state and the decoded write.
    always_comb begin
        state_nx = state;
        unique case (op)
            OP_ARM:  state_nx = ST_ARMED;
            OP_CONF: state_nx = (state == ST_ARMED) ? ST_CONF : ST_IDLE;
            OP_KEYA: state_nx = (state == ST_CONF && wr_data == KEYA_VAL)
                                ? ST_KEY1 : ST_IDLE;
            OP_KEYB: state_nx = (state == ST_KEY1 && wr_data == KEYB_VAL)
                                ? ST_KEY2 : ST_IDLE;
            OP_KEYC: state_nx = (state == ST_KEY2 && wr_data == KEYC_VAL)
                                ? ST_READY : ST_IDLE;
            OP_COMMIT: begin
                if (state == ST_READY || state > ST_READY) state_nx = ST_IDLE;
            end
            default: state_nx = state;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/bsw_bank.sv
// Module: bsw_bank
// Holds the pending and active bank halves and adds the active offset to
// the read address. Each offset is either 0 or half the address space,
// so each one is kept as a single bit.
// Assumes: arm and commit never need to happen in the same cycle.
module bsw_bank #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              arm_low,
    input  logic              commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] cart_addr,
    output logic              active_hi
);
    logic pending_hi;

    // Latch the half picked by the arming write (select bit set = low half).
    always_ff @(posedge clk) begin
        if (!rst_n)   pending_hi <= 1'b0;
        else if (arm) pending_hi <= ~arm_low;
    end

    // Copy the pending half into the active half on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      active_hi <= 1'b0;
        else if (commit) active_hi <= pending_hi;
    end

    // Add the offset; the sum wraps at the address width.
    assign cart_addr = rd_addr + {active_hi, {(ADDR_W-1){1'b0}}};
endmodule

// File: rtl/bank_seq_switch.sv
// Module: bank_seq_switch (top)
// Watches peripheral writes for the arming chain and translates cartridge
// read addresses through the selected 32 KB half.
// Assumes: a single-cycle write strobe, and a read address that the
// surrounding logic already limits to the cartridge range.
module bank_seq_switch
    import bsw_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int WIN_BIT = 12,
    parameter int SEL_W   = 4,
    parameter int SEL_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] cart_addr,
    output logic [2:0]        seq_state
);
    wr_op_t             op;
    logic               commit;
    logic               active_hi;
    logic [STATE_W-1:0] state;

    bsw_decode #(
        .ADDR_W(ADDR_W), .WIN_BIT(WIN_BIT), .SEL_W(SEL_W)
    ) u_decode (
        .wr_addr(wr_addr), .wr_en(wr_en), .op(op)
    );

    bsw_seq #(
        .DATA_W(DATA_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .op(op), .wr_data(wr_data),
        .state(state), .commit(commit)
    );

    bsw_bank #(
        .ADDR_W(ADDR_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .arm(op == OP_ARM), .arm_low(wr_data[SEL_BIT]),
        .commit(commit), .rd_addr(rd_addr),
        .cart_addr(cart_addr), .active_hi(active_hi)
    );

    assign seq_state = state;
endmodule

// File: rtl/bsw_checker.sv
// Module: bsw_checker
// Properties on the chain order and on the address translation. It is
// attached to the top module through the bind statement at the end of
// this file.
module bsw_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] cart_addr,
    input logic [2:0]        seq_state,
    input logic              active_hi
);
    logic       hit;
    logic [3:0] sel;
    assign hit = wr_en & wr_addr[12];
    assign sel = wr_addr[3:0];

    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state <= 3'd5); // R10
    AST_ARM_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        hit && sel == 4'd2 |=> seq_state == 3'd1); // R2
    AST_CONF_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        hit && sel == 4'd3 && seq_state != 3'd1 |=> seq_state == 3'd0); // R3
    AST_KEYA_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        hit && sel == 4'd0 && (seq_state != 3'd2 || wr_data != 8'h01)
        |=> seq_state == 3'd0); // R4
    AST_KEYB_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        hit && sel == 4'd1 && seq_state == 3'd3 && wr_data == 8'h00
        |=> seq_state == 3'd4); // R5
    AST_KEYC_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        hit && sel == 4'd11 && seq_state == 3'd4 && wr_data == 8'h98
        |=> seq_state == 3'd5); // R6
    AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit && sel == 4'd4 && seq_state == 3'd5 |=> seq_state == 3'd0); // R7
    AST_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hit && sel == 4'd4 && seq_state != 3'd5
        |=> $stable(seq_state) && $stable(active_hi)); // R7
    AST_OUTSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(seq_state) && $stable(active_hi)); // R9

    // Translated address against the offset register, checked every edge.
    always @(negedge clk) begin
        if (rst_n) begin
            AST_XLATE: assert (cart_addr == ADDR_W'(rd_addr + (active_hi ? 32768 : 0))); // R8
        end
    end
endmodule

bind bank_seq_switch bsw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_addr(rd_addr), .cart_addr(cart_addr),
    .seq_state(seq_state), .active_hi(active_hi)
);

// File: tb/tb_bank_seq_switch.sv
`timescale 1ns/1ps
module tb_bank_seq_switch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] wr_addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] rd_addr = '0;
    logic [15:0] cart_addr;
    logic [2:0]  seq_state;

    int checks = 0;
    int failures = 0;

    bank_seq_switch dut (
        .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_addr(rd_addr), .cart_addr(cart_addr),
        .seq_state(seq_state)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One strobed write between falling edges; the result is seen on return.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] ra(input int r, input int hi);
        return 16'(16'h1000 | (hi << 13) | (((hi * 5) & 8'hff) << 4) | r);
    endfunction

    task automatic sweep(input int off, input string req);
        for (int a = 0; a < 32768; a += 1931) begin
            rd_addr = 16'(a);
            #1;
            chk(req, cart_addr, (a + off) & 16'hffff);
        end
    endtask

    // Walk the chain up to the given state; sel6 picks the arming data.
    task automatic reach(input int st, input logic sel6);
        if (st >= 1) wr(ra(2, 1), sel6 ? 8'h40 : 8'h00);
        if (st >= 2) wr(ra(3, 2), 8'h55);
        if (st >= 3) wr(ra(0, 3), 8'h01);
        if (st >= 4) wr(ra(1, 4), 8'h00);
        if (st >= 5) wr(ra(11, 5), 8'h98);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 state", seq_state, 0);
        sweep(0, "R1 offset during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 state after release", seq_state, 0);
        sweep(0, "R1 R8 offset zero");

        // Full chain, bit 6 clear: upper half, with each step checked.
        wr(ra(2, 0), 8'h3f); chk("R2 R10 armed", seq_state, 1);
        wr(ra(3, 7), 8'hff); chk("R3 confirm", seq_state, 2);
        wr(ra(0, 6), 8'h01); chk("R4 key a", seq_state, 3);
        wr(ra(1, 1), 8'h00); chk("R5 key b", seq_state, 4);
        wr(ra(11, 2), 8'h98); chk("R6 key c", seq_state, 5);
        sweep(0, "R7 no switch before commit");
        wr(ra(4, 3), 8'h12); chk("R7 commit idle", seq_state, 0);
        sweep(32768, "R7 R8 upper half");

        // Register 4 in states 0..4 leaves state and offset alone.
        for (int s = 0; s <= 4; s++) begin
            reach(s, 1'b1);
            wr(ra(4, s), 8'h00);
            chk("R7 commit ignored", seq_state, s);
        end
        sweep(32768, "R7 offset kept");

        // Bank back to the low half via bit 6 set.
        reach(5, 1'b1);
        wr(ra(4, 0), 8'h00);
        chk("R7 commit low", seq_state, 0);
        sweep(0, "R2 R7 low half");

        // Re-arm overrides the pending choice; latest arming write wins.
        wr(ra(2, 0), 8'h40);
        reach(5, 1'b0);
        wr(ra(4, 0), 8'h00);
        sweep(32768, "R2 latest arm wins");

        // Register 2 from every state goes to state 1.
        for (int s = 0; s <= 5; s++) begin
            reach(s, 1'b0);
            wr(ra(2, 3), 8'h40);
            chk("R2 arm from any", seq_state, 1);
        end
        wr(ra(3, 0), 8'h00); wr(ra(0, 0), 8'h01); wr(ra(1, 0), 8'h00);
        wr(ra(11, 0), 8'h98); wr(ra(4, 0), 8'h00);
        sweep(0, "R2 rearm low half");

        // Register 3 outside state 1 drops to idle.
        for (int s = 0; s <= 5; s++) begin
            if (s != 1) begin
                reach(s, 1'b0);
                wr(ra(3, 1), 8'h00);
                chk("R3 out of order", seq_state, 0);
            end
        end

        // Wrong data at each keyed step, and keyed writes in wrong states.
        for (int d = 0; d < 256; d += 17) begin
            reach(2, 1'b0); wr(ra(0, 0), 8'(d));
            chk("R4 key a data", seq_state, (d == 1) ? 3 : 0);
            reach(3, 1'b0); wr(ra(1, 0), 8'(d));
            chk("R5 key b data", seq_state, (d == 0) ? 4 : 0);
            reach(4, 1'b0); wr(ra(11, 0), 8'(d));
            chk("R6 key c data", seq_state, (d == 8'h98) ? 5 : 0);
        end
        reach(4, 1'b0); wr(ra(11, 0), 8'h99); chk("R6 near key", seq_state, 0);
        reach(1, 1'b0); wr(ra(0, 0), 8'h01); chk("R4 wrong state", seq_state, 0);
        reach(2, 1'b0); wr(ra(1, 0), 8'h00); chk("R5 wrong state", seq_state, 0);
        reach(3, 1'b0); wr(ra(11, 0), 8'h98); chk("R6 wrong state", seq_state, 0);
        sweep(0, "R4 R5 R6 offset kept after aborts");

        // Unrelated registers, window bit clear, and no strobe are ignored.
        for (int r = 0; r < 16; r++) begin
            if (!(r inside {0, 1, 2, 3, 4, 11})) begin
                reach(4, 1'b0);
                wr(ra(r, 2), 8'h98);
                chk("R9 other register", seq_state, 4);
            end
        end
        for (int r = 0; r < 16; r++) begin
            reach(5, 1'b0);
            wr(16'(16'hEF00 | r), 8'h40);
            chk("R9 window bit clear", seq_state, 5);
        end
        @(negedge clk);
        wr_addr = ra(4, 0); wr_data = 8'h00;
        repeat (3) @(negedge clk);
        chk("R9 no strobe", seq_state, 5);
        sweep(0, "R9 offset kept");
        wr(ra(4, 0), 8'h00);
        sweep(32768, "R9 commit after ignored writes");

        // Reset in mid chain clears state and active offset.
        reach(3, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid reset state", seq_state, 0);
        rst_n = 1'b1;
        @(negedge clk);
        sweep(0, "R1 mid reset offset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule